// File: doc/BRIEF.md
# Threshold-Pruned Add-Compare-Select Unit

This block is the path-extension and pruning core of an adaptive Viterbi decoder for a rate-1/2 convolutional code. A full decoder tracks every one of the 2^(K-1) trellis states. This unit keeps a short, variable list of surviving paths instead. Each time step it receives that list (encoder state and normalized accumulated metric per path) together with the received symbol pair. It then grows each survivor along both input-bit branches and keeps only the extensions that pass a threshold test.

If too many extensions pass, the unit lowers the threshold in fixed steps and runs the test again, one step per cycle, until the list fits the configured cap. No sorting is used. Extensions that land on the same encoder state are merged. The kept list is then packed, and its metrics are rebased so the best path is zero. The list is presented together with per-path decision bits and parent indices, which a separate survivor memory records. A one-cycle strobe marks the result as final, and the next symbol pair is taken only once the unit is idle again.

Top module: `avd_acs_prune`

## Requirements
- R1: Survivor p (p below `in_count`) with state s yields two candidates, index c = 2p+b for input bit b. The encoder window is w = {s, b}, K bits with b in the least significant bit. The coded bits are o0 = parity(w & G0) and o1 = parity(w & G1), with G0 = 7'o171 and G1 = 7'o133 by default. The branch metric is (o0 != rx_sym[1]) + (o1 != rx_sym[0]). The candidate metric is the survivor metric plus the branch metric, and the next state is {s[K-3:0], b}.
- R2: A candidate passes only when its metric is strictly less than dm + T. Here dm is the smallest metric among the first `in_count` input survivors, or 0 when `in_count` is 0.
- R3: If more than NMAX candidates remain after merging, T drops by 2 (saturating at 0) and the test repeats. `out_count` never exceeds NMAX, and `out_thr` reports the T that produced the final list.
- R4: Every accepted step starts from the configured T (default 17), and T never rises while the unit is busy.
- R5: If two passing candidates share a next state, only the one with the lower metric is kept. On equal metrics, the lower candidate index is kept.
- R6: Kept candidates fill output slots 0 upward in ascending candidate index. Each slot carries the state, `out_bits` = b and `out_parent` = p. Slots at or above `out_count` read zero.
- R7: `out_dmin` is the smallest raw metric among kept candidates (0 if none are kept). Each `out_metrics` slot is its raw metric minus `out_dmin`.
- R8: `start` is taken only while `busy` is low. `done` pulses for exactly one cycle, with `busy` low, when the outputs update. A `start` that arrives while busy has no effect on the result.
- R9: After reset, `busy`, `done` and `out_count` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Accept a new time step when idle |
| rx_sym | input | 2 | Received pair; bit 1 pairs with o0, bit 0 with o1 |
| in_count | input | $clog2(NMAX+1) | Number of valid input survivors |
| in_states | input | NMAX*(K-1) | Survivor states, slot i at [i*(K-1) +: K-1] |
| in_metrics | input | NMAX*MW | Survivor metrics, slot i at [i*MW +: MW] |
| busy | output | 1 | Evaluation in progress |
| done | output | 1 | One-cycle strobe: outputs are final |
| out_count | output | $clog2(NMAX+1) | Number of kept paths |
| out_states | output | NMAX*(K-1) | Kept next states |
| out_metrics | output | NMAX*MW | Rebased kept metrics |
| out_bits | output | NMAX | Decision bit of each kept path |
| out_parent | output | NMAX*$clog2(NMAX) | Parent survivor index of each kept path |
| out_dmin | output | MW | Raw minimum kept metric |
| out_thr | output | $clog2(T_INIT+1) | Threshold that produced the list |

## Verification
Random steps use survivor lists of random length, states and small metrics, so both the threshold cut and the state merge are exercised on ordinary traffic. A list of eight zero-metric survivors with distinct states forces several threshold decrements; this tells a correct step size and stopping point apart from an off-by-one. Two survivors whose states differ only in the top bit meet on the same next states, and with equal metrics this shows which one the tie rule keeps. An empty list and a start pulse sent mid-evaluation check the degenerate result and that a busy unit ignores new input.

// File: rtl/avd_pkg.sv
package avd_pkg;
  typedef enum logic {PH_IDLE = 1'b0, PH_EVAL = 1'b1} phase_t;
endpackage

// File: rtl/avd_branch.sv
module avd_branch #(
  parameter int SW  = 6,
  parameter int MW  = 8,
  parameter int G0  = 'o171,
  parameter int G1  = 'o133,
  parameter int BIT = 0
) (
  input  logic [SW-1:0] st,
  input  logic [MW-1:0] met,
  input  logic [1:0]    rx,
  output logic [SW-1:0] nst,
  output logic [MW:0]   cmet
);
  localparam logic [SW:0] P0 = (SW+1)'(G0);
  localparam logic [SW:0] P1 = (SW+1)'(G1);
  localparam logic        B  = 1'(BIT);

  logic [SW:0] win;
  logic        o0, o1;

  always_comb begin
    win  = {st, B};
    o0   = ^(win & P0);
    o1   = ^(win & P1);
    nst  = {st[SW-2:0], B};
    cmet = {1'b0, met} + (MW+1)'(o0 ^ rx[1]) + (MW+1)'(o1 ^ rx[0]);
  end
endmodule

// File: rtl/avd_prune.sv
module avd_prune #(
  parameter int N2 = 16,
  parameter int SW = 6,
  parameter int MW = 8,
  parameter int CW = 5
) (
  input  logic [N2-1:0]         cval,
  input  logic [N2-1:0][SW-1:0] cst,
  input  logic [N2-1:0][MW:0]   cmet,
  input  logic [MW:0]           bound,
  output logic [N2-1:0]         keep,
  output logic [CW-1:0]         kcount
);
  logic [N2-1:0] pass;

  always_comb begin
    for (int i = 0; i < N2; i++) pass[i] = cval[i] && (cmet[i] < bound);
    kcount = '0;
    for (int i = 0; i < N2; i++) begin
      keep[i] = pass[i];
      for (int j = 0; j < N2; j++) begin
        if (j != i && pass[j] && cst[j] == cst[i] &&
            ((cmet[j] < cmet[i]) || (cmet[j] == cmet[i] && j < i)))
          keep[i] = 1'b0;
      end
      kcount = kcount + CW'(keep[i]);
    end
  end
endmodule

// File: rtl/avd_pack.sv
module avd_pack #(
  parameter int N2   = 16,
  parameter int NMAX = 8,
  parameter int SW   = 6,
  parameter int MW   = 8,
  parameter int PW   = 3
) (
  input  logic [N2-1:0]           keep,
  input  logic [N2-1:0][SW-1:0]   cst,
  input  logic [N2-1:0][MW:0]     cmet,
  output logic [NMAX-1:0][SW-1:0] ost,
  output logic [NMAX-1:0][MW-1:0] omet,
  output logic [NMAX-1:0]         obit,
  output logic [NMAX-1:0][PW-1:0] opar,
  output logic [MW-1:0]           omin
);
  logic [MW:0] mn;
  int          slot;

  always_comb begin
    mn = '1;
    for (int j = 0; j < N2; j++)
      if (keep[j] && cmet[j] < mn) mn = cmet[j];
    if (keep == '0) mn = '0;
    omin = mn[MW-1:0];

    ost  = '0;
    omet = '0;
    obit = '0;
    opar = '0;
    slot = 0;
    for (int j = 0; j < N2; j++) begin
      if (keep[j]) begin
        if (slot < NMAX) begin
          ost[slot]  = cst[j];
          omet[slot] = MW'(cmet[j] - mn);
          obit[slot] = 1'(j % 2);
          opar[slot] = PW'(j / 2);
        end
        slot = slot + 1;
      end
    end
  end
endmodule

// File: rtl/avd_acs_prune.sv
module avd_acs_prune #(
  parameter int K      = 7,
  parameter int NMAX   = 8,
  parameter int MW     = 8,
  parameter int T_INIT = 17,
  parameter int T_STEP = 2,
  parameter int G0     = 'o171,
  parameter int G1     = 'o133,
  localparam int SW    = K - 1,
  localparam int N2    = 2 * NMAX,
  localparam int OCW   = $clog2(NMAX + 1),
  localparam int CW    = $clog2(N2 + 1),
  localparam int PW    = $clog2(NMAX),
  localparam int TW    = $clog2(T_INIT + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [1:0]           rx_sym,
  input  logic [OCW-1:0]       in_count,
  input  logic [NMAX*SW-1:0]   in_states,
  input  logic [NMAX*MW-1:0]   in_metrics,
  output logic                 busy,
  output logic                 done,
  output logic [OCW-1:0]       out_count,
  output logic [NMAX*SW-1:0]   out_states,
  output logic [NMAX*MW-1:0]   out_metrics,
  output logic [NMAX-1:0]      out_bits,
  output logic [NMAX*PW-1:0]   out_parent,
  output logic [MW-1:0]        out_dmin,
  output logic [TW-1:0]        out_thr
);
  import avd_pkg::*;

  phase_t                  ph_q;
  logic [1:0]              rx_q;
  logic [OCW-1:0]          cnt_q;
  logic [NMAX-1:0][SW-1:0] sts_q;
  logic [NMAX-1:0][MW-1:0] mets_q;
  logic [TW-1:0]           thr_q;
  logic [MW-1:0]           dm_q;
  logic [MW-1:0]           dm_in;

  // smallest metric among the valid incoming survivors
  always_comb begin
    dm_in = '1;
    for (int i = 0; i < NMAX; i++)
      if (i < int'(in_count) && in_metrics[i*MW +: MW] < dm_in)
        dm_in = in_metrics[i*MW +: MW];
    if (in_count == '0) dm_in = '0;
  end

  logic [N2-1:0]           cval;
  logic [N2-1:0][SW-1:0]   cst;
  logic [N2-1:0][MW:0]     cmet;

  for (genvar p = 0; p < NMAX; p++) begin : g_surv
    for (genvar b = 0; b < 2; b++) begin : g_br
      avd_branch #(.SW(SW), .MW(MW), .G0(G0), .G1(G1), .BIT(b)) br_i (
        .st(sts_q[p]), .met(mets_q[p]), .rx(rx_q),
        .nst(cst[2*p+b]), .cmet(cmet[2*p+b])
      );
      assign cval[2*p+b] = (p < int'(cnt_q));
    end
  end

  logic [MW:0]   bound;
  logic [N2-1:0] keep;
  logic [CW-1:0] kcount;

  assign bound = (MW+1)'(dm_q) + (MW+1)'(thr_q);

  avd_prune #(.N2(N2), .SW(SW), .MW(MW), .CW(CW)) prune_i (
    .cval(cval), .cst(cst), .cmet(cmet), .bound(bound),
    .keep(keep), .kcount(kcount)
  );

  logic [NMAX-1:0][SW-1:0] pk_st;
  logic [NMAX-1:0][MW-1:0] pk_met;
  logic [NMAX-1:0]         pk_bit;
  logic [NMAX-1:0][PW-1:0] pk_par;
  logic [MW-1:0]           pk_min;

  avd_pack #(.N2(N2), .NMAX(NMAX), .SW(SW), .MW(MW), .PW(PW)) pack_i (
    .keep(keep), .cst(cst), .cmet(cmet),
    .ost(pk_st), .omet(pk_met), .obit(pk_bit), .opar(pk_par), .omin(pk_min)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q        <= PH_IDLE;
      rx_q        <= '0;
      cnt_q       <= '0;
      sts_q       <= '0;
      mets_q      <= '0;
      thr_q       <= TW'(T_INIT);
      dm_q        <= '0;
      done        <= 1'b0;
      out_count   <= '0;
      out_states  <= '0;
      out_metrics <= '0;
      out_bits    <= '0;
      out_parent  <= '0;
      out_dmin    <= '0;
      out_thr     <= '0;
    end else begin
      done <= 1'b0;
      case (ph_q)
        PH_IDLE: if (start) begin
          rx_q   <= rx_sym;
          cnt_q  <= in_count;
          sts_q  <= in_states;
          mets_q <= in_metrics;
          dm_q   <= dm_in;
          thr_q  <= TW'(T_INIT);
          ph_q   <= PH_EVAL;
        end
        PH_EVAL: if (kcount > CW'(NMAX)) begin
          thr_q <= (thr_q >= TW'(T_STEP)) ? thr_q - TW'(T_STEP) : '0;
        end else begin
          out_count   <= OCW'(kcount);
          out_states  <= pk_st;
          out_metrics <= pk_met;
          out_bits    <= pk_bit;
          out_parent  <= pk_par;
          out_dmin    <= pk_min;
          out_thr     <= thr_q;
          done        <= 1'b1;
          ph_q        <= PH_IDLE;
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign busy = (ph_q == PH_EVAL);
endmodule

// File: rtl/avd_acs_prune_chk.sv
module avd_acs_prune_chk #(
  parameter int NMAX   = 8,
  parameter int T_INIT = 17,
  parameter int OCW    = 4,
  parameter int TW     = 5
) (
  input logic           clk,
  input logic           rst,
  input logic           start,
  input logic           busy,
  input logic           done,
  input logic [OCW-1:0] out_count,
  input logic [TW-1:0]  out_thr,
  input logic [TW-1:0]  thr_q
);
  // R3
  cap_respected_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (int'(out_count) <= NMAX));

  // R3
  thr_reported_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (int'(out_thr) <= T_INIT));

  // R4
  thr_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (int'(thr_q) == T_INIT));

  // R4
  thr_monotone_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> (thr_q <= $past(thr_q)));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R8
  accept_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
endmodule

bind avd_acs_prune avd_acs_prune_chk #(
  .NMAX(NMAX), .T_INIT(T_INIT), .OCW(OCW), .TW(TW)
) chk_i (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .out_count(out_count), .out_thr(out_thr), .thr_q(thr_q)
);

// File: tb/avd_acs_prune_tb_top.sv
module avd_acs_prune_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int K      = 7;
  localparam int NMAX   = 8;
  localparam int MW     = 8;
  localparam int T_INIT = 17;
  localparam int SW     = K - 1;
  localparam int N2     = 2 * NMAX;
  localparam int OCW    = $clog2(NMAX + 1);
  localparam int PW     = $clog2(NMAX);
  localparam int TW     = $clog2(T_INIT + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [1:0]         rx_sym = '0;
  logic [OCW-1:0]     in_count = '0;
  logic [NMAX*SW-1:0] in_states = '0;
  logic [NMAX*MW-1:0] in_metrics = '0;
  logic               busy, done;
  logic [OCW-1:0]     out_count;
  logic [NMAX*SW-1:0] out_states;
  logic [NMAX*MW-1:0] out_metrics;
  logic [NMAX-1:0]    out_bits;
  logic [NMAX*PW-1:0] out_parent;
  logic [MW-1:0]      out_dmin;
  logic [TW-1:0]      out_thr;

  always #(CLK_PERIOD/2) clk = ~clk;

  avd_acs_prune dut_i (
    .clk(clk), .rst(rst), .start(start), .rx_sym(rx_sym), .in_count(in_count),
    .in_states(in_states), .in_metrics(in_metrics), .busy(busy), .done(done),
    .out_count(out_count), .out_states(out_states), .out_metrics(out_metrics),
    .out_bits(out_bits), .out_parent(out_parent), .out_dmin(out_dmin), .out_thr(out_thr)
  );

  int checks = 0;
  int fails  = 0;

  // stimulus kept in bench arrays
  int s_cnt, s_rx;
  int s_st[NMAX];
  int s_mt[NMAX];
  // expected results
  int e_cnt, e_dmin, e_thr;
  int e_st[NMAX], e_mt[NMAX], e_bit[NMAX], e_par[NMAX];

  function automatic int parity7(int v);
    int r = 0;
    for (int i = 0; i < K; i++) r = r ^ ((v >> i) & 1);
    return r;
  endfunction

  task automatic compute_exp();
    int dm, thr, kc, slot, mn;
    int cm[N2];
    int cs[N2];
    bit cv[N2];
    bit pass[N2];
    bit kp[N2];
    dm = 0;
    if (s_cnt > 0) begin
      dm = s_mt[0];
      for (int p = 1; p < s_cnt; p++) if (s_mt[p] < dm) dm = s_mt[p];
    end
    for (int c = 0; c < N2; c++) begin
      int p = c / 2, b = c % 2, w, o0, o1;
      w  = (s_st[p] << 1) | b;                       // R1 window {s,b}
      o0 = parity7(w & 'o171);
      o1 = parity7(w & 'o133);
      cm[c] = s_mt[p] + (o0 ^ ((s_rx >> 1) & 1)) + (o1 ^ (s_rx & 1));
      cs[c] = w & ((1 << SW) - 1);
      cv[c] = (p < s_cnt);
    end
    thr = T_INIT;
    for (int guard = 0; guard < 64; guard++) begin
      kc = 0;
      for (int c = 0; c < N2; c++) pass[c] = cv[c] && (cm[c] < dm + thr);   // R2
      for (int c = 0; c < N2; c++) begin
        kp[c] = pass[c];
        for (int d = 0; d < N2; d++)
          if (d != c && pass[d] && cs[d] == cs[c] &&
              (cm[d] < cm[c] || (cm[d] == cm[c] && d < c))) kp[c] = 0; // R5
        if (kp[c]) kc++;
      end
      if (kc <= NMAX) break;
      thr = (thr >= 2) ? thr - 2 : 0;                                        // R3
    end
    mn = 0;
    for (int c = N2 - 1; c >= 0; c--) if (kp[c] && (mn == 0 || cm[c] < mn + 0)) mn = mn;
    mn = 1 << 20;
    for (int c = 0; c < N2; c++) if (kp[c] && cm[c] < mn) mn = cm[c];
    if (kc == 0) mn = 0;
    for (int i = 0; i < NMAX; i++) begin e_st[i] = 0; e_mt[i] = 0; e_bit[i] = 0; e_par[i] = 0; end
    slot = 0;
    for (int c = 0; c < N2; c++) if (kp[c]) begin
      e_st[slot] = cs[c]; e_mt[slot] = cm[c] - mn; e_bit[slot] = c % 2; e_par[slot] = c / 2;
      slot++;
    end
    e_cnt = kc; e_dmin = mn; e_thr = thr;
  endtask

  task automatic load_inputs();
    in_count = OCW'(s_cnt);
    rx_sym   = 2'(s_rx);
    for (int i = 0; i < NMAX; i++) begin
      in_states[i*SW +: SW]  = SW'(s_st[i]);
      in_metrics[i*MW +: MW] = MW'(s_mt[i]);
    end
  endtask

  task automatic wait_done(output bit ok);
    ok = 0;
    for (int n = 0; n < 200; n++) begin
      @(negedge clk);
      if (done) begin ok = 1; break; end
    end
  endtask

  task automatic check_int(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compare_all(string tag);
    bit slots_ok = 1;
    check_int({tag, " R3 out_count"}, int'(out_count), e_cnt);
    check_int({tag, " R3 out_thr"}, int'(out_thr), e_thr);
    check_int({tag, " R7 out_dmin"}, int'(out_dmin), e_dmin);
    for (int i = 0; i < NMAX; i++) begin
      if (int'(out_states[i*SW +: SW]) != e_st[i] || int'(out_metrics[i*MW +: MW]) != e_mt[i] ||
          int'(out_bits[i]) != e_bit[i] || int'(out_parent[i*PW +: PW]) != e_par[i]) begin
        if (slots_ok)
          $display("FAIL %s R1/R5/R6/R7 slot %0d actual st=%0d m=%0d b=%0d p=%0d expected st=%0d m=%0d b=%0d p=%0d",
                   tag, i, out_states[i*SW +: SW], out_metrics[i*MW +: MW], out_bits[i],
                   out_parent[i*PW +: PW], e_st[i], e_mt[i], e_bit[i], e_par[i]);
        slots_ok = 0;
      end
    end
    checks++;
    if (!slots_ok) fails++;
  endtask

  task automatic run_step(string tag);
    bit ok;
    compute_exp();
    @(negedge clk);
    load_inputs();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(ok);
    check_int({tag, " R8 done seen"}, int'(ok), 1);
    if (ok) compare_all(tag);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    bit ok;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    check_int("R9 busy", int'(busy), 0);
    check_int("R9 done", int'(done), 0);
    check_int("R9 out_count", int'(out_count), 0);

    // R1 single survivor, state 0, metric 0
    s_cnt = 1; s_rx = 0;
    for (int i = 0; i < NMAX; i++) begin s_st[i] = 0; s_mt[i] = 0; end
    run_step("single");

    // R2 empty list gives empty result
    s_cnt = 0; s_rx = 3;
    run_step("empty");

    // R3 eight zero-metric survivors force threshold shrink
    s_cnt = NMAX; s_rx = 1;
    for (int i = 0; i < NMAX; i++) begin s_st[i] = i * 5; s_mt[i] = 0; end
    run_step("shrink");
    check_int("R3 shrink lowered T", int'(out_thr < TW'(T_INIT)), 1);

    // R5 merge with tie: states differ only in top bit, equal metrics
    s_cnt = 2; s_rx = 2;
    s_st[0] = 6'h25; s_st[1] = 6'h05; s_mt[0] = 3; s_mt[1] = 3;
    run_step("tie");
    check_int("R5 tie keeps higher-index-free list", int'(out_count), 2);

    // R5 merge where the later survivor is better
    s_cnt = 2; s_rx = 0;
    s_st[0] = 6'h11; s_st[1] = 6'h31; s_mt[0] = 4; s_mt[1] = 0;
    run_step("merge");

    // R8 start while busy is ignored
    s_cnt = NMAX; s_rx = 0;
    for (int i = 0; i < NMAX; i++) begin s_st[i] = i * 7 + 1; s_mt[i] = 0; end
    compute_exp();
    @(negedge clk);
    load_inputs();
    start = 1'b1;
    @(negedge clk);
    check_int("R8 busy after start", int'(busy), 1);
    in_count = OCW'(1); rx_sym = 2'd3; in_metrics = '0; in_states = '1;
    @(negedge clk);
    start = 1'b0;
    wait_done(ok);
    check_int("R8 busy start done", int'(ok), 1);
    if (ok) compare_all("busy-start");
    @(negedge clk);
    check_int("R8 done one cycle", int'(done), 0);

    // random traffic
    for (int n = 0; n < 400; n++) begin
      s_cnt = $urandom_range(1, NMAX);
      s_rx  = $urandom_range(0, 3);
      for (int i = 0; i < NMAX; i++) begin
        s_st[i] = $urandom_range(0, (1 << SW) - 1);
        s_mt[i] = $urandom_range(0, 14);
      end
      run_step("random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule